// File: doc/BRIEF.md
# I2C Register-File Target with Deferred Page Commit

This block is an I2C target that connects an external two-wire bus to an on-chip register file. It samples SCL and SDA with the system clock and recognises START, repeated START and STOP conditions. It checks the address byte against a 7-bit address whose two low-order variable bits come from strap pins. It drives SDA only through an open-drain enable. An internal pointer selects the register. The first byte after a write address loads the pointer, and every byte after that is a data byte.

Each acknowledged data byte goes straight to the live register file as a one-cycle write strobe. The copy into nonvolatile storage is deferred. The block remembers which offsets of the current aligned page were written, and it signals a single commit pulse after the STOP that closes the transfer. Reads return the register at the pointer. They continue byte after byte while the host acknowledges, and they stop when the host sends a not-acknowledge.

Top module: `i2c_regfile_target`

## Requirements
- R1: A falling SDA while SCL is high is a START, and a repeated START is treated the same way. A rising SDA while SCL is high is a STOP. Either condition releases SDA and ends the byte in progress. A START restarts address matching.
- R2: The byte after a START is taken MSB first, on rising SCL edges. Its bits 7:1 must equal {1011, strap_i[1], strap_i[0], 0}, and bit 0 selects read (1) or write (0). With both straps low, the write byte is B0h and the read byte is B1h. On a match the target drives SDA low (ACK) for the 9th clock.
- R3: On an address mismatch the target leaves SDA released in the 9th bit (NACK). Until the next START it drives nothing and writes nothing.
- R4: In a write, the second byte loads the pointer and is acknowledged. Each later byte is acknowledged, and at the end of its ACK bit it produces a one-cycle reg_we_o carrying the pointer address and the byte. This happens before any STOP.
- R5: During a write the pointer advances after each data byte and wraps inside the aligned 8-byte page. It never crosses into the next page, so the 9th byte overwrites the first.
- R6: After a STOP, commit_o pulses for one cycle if data bytes were written since the last pointer load. It carries the page base (the pointer with its low 3 bits cleared) and an 8-bit mask in which bit i marks offset i. No pulse follows a STOP when no data byte was written.
- R7: In a read, the target shifts out the byte at the pointer MSB first, changing SDA after falling SCL edges. The pointer advances by one after each byte, across page boundaries. A host ACK makes the target send the next byte.
- R8: After a host NACK the target releases SDA and drives nothing until the next START.
- R9: Out of reset, sda_oe_o, reg_we_o and commit_o are all low.
- R10: A change of strap_i changes the matched address, so with straps 11 the write byte is BCh and B0h is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 2 | Address strap pins, [1] and [0] |
| reg_raddr_o | output | ADDR_W | Read address (the pointer) |
| reg_rdata_i | input | 8 | Register value at reg_raddr_o |
| reg_we_o | output | 1 | Live register write strobe |
| reg_waddr_o | output | ADDR_W | Write address |
| reg_wdata_o | output | 8 | Write data |
| commit_o | output | 1 | Nonvolatile commit request pulse |
| commit_base_o | output | ADDR_W | Base address of committed page |
| commit_mask_o | output | PAGE_BYTES | Offsets written in that page |

## Verification
In a single cycle, the live write strobe and the page-wrap step of the pointer both occur, while the same byte also sets its bit in the commit mask. The bench provokes this with a nine-byte write that starts mid-page, so one strobe lands on an offset that is already marked. It judges the result by the register contents: the ninth byte overwrites the first address and the page after it stays untouched. It also checks that exactly one commit follows, with a full mask and the original page base.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK
   } xfer_state_e;

   localparam logic [3:0] ADDR_PREFIX = 4'b1011;

endpackage

// File: rtl/i2c_rf_linefront.sv
module i2c_rf_linefront #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_sh;
   logic [SYNC_STAGES-1:0] sda_sh;
   logic                   scl_p;
   logic                   sda_p;
   logic                   scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_p  <= scl_sh[SYNC_STAGES-1];
         sda_p  <= sda_sh[SYNC_STAGES-1];
      end
   end

   assign scl_q     = scl_sh[SYNC_STAGES-1];
   assign sda_q     = sda_sh[SYNC_STAGES-1];
   assign scl_rise  = scl_q & ~scl_p;
   assign scl_fall  = ~scl_q & scl_p;
   assign start_det = scl_q & scl_p & sda_p & ~sda_q;
   assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
   import i2c_rf_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int PAGE_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_q,
   input  logic [1:0]        strap_i,
   input  logic [7:0]        rd_data,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] ptr,
   output logic              ptr_load,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [7:0]        wdata
);

   localparam int PAGE_W = $clog2(PAGE_BYTES);
   localparam logic [PAGE_W-1:0] OFF_ONE = PAGE_W'(1);
   localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

   xfer_state_e       state;
   logic [3:0]        bitcnt;
   logic [7:0]        shreg;
   logic [6:0]        tx;
   logic              rw;
   logic              mack;
   logic              addr_hit;
   logic [ADDR_W-1:0] page_next;

   assign addr_hit = (shreg[7:1] == {ADDR_PREFIX, strap_i, 1'b0});

   generate
      if (PAGE_W == ADDR_W) begin : g_flat
         assign page_next = ptr + PTR_ONE;
      end else begin : g_paged
         assign page_next = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + OFF_ONE};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         tx       <= '0;
         rw       <= 1'b0;
         mack     <= 1'b0;
         sda_oe   <= 1'b0;
         ptr      <= '0;
         ptr_load <= 1'b0;
         we       <= 1'b0;
         waddr    <= '0;
         wdata    <= '0;
      end else begin
         we       <= 1'b0;
         ptr_load <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_PTR, ST_WDATA: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[6:0], sda_q};
                     bitcnt <= bitcnt + 4'd1;
                  end
                  if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     if (state == ST_ADDR) begin
                        if (addr_hit) begin
                           sda_oe <= 1'b1;
                           rw     <= shreg[0];
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state  <= ST_IDLE;
                        end
                     end else if (state == ST_PTR) begin
                        sda_oe <= 1'b1;
                        state  <= ST_PTR_ACK;
                     end else begin
                        sda_oe <= 1'b1;
                        state  <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw) begin
                        tx     <= rd_data[6:0];
                        sda_oe <= ~rd_data[7];
                        state  <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_PTR;
                     end
                  end
               end
               ST_PTR_ACK: begin
                  if (scl_fall) begin
                     sda_oe   <= 1'b0;
                     ptr      <= shreg[ADDR_W-1:0];
                     ptr_load <= 1'b1;
                     state    <= ST_WDATA;
                  end
               end
               ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     we     <= 1'b1;
                     waddr  <= ptr;
                     wdata  <= shreg;
                     ptr    <= page_next;
                     state  <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     bitcnt <= bitcnt + 4'd1;
                  end
                  if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RDATA_ACK;
                     end else begin
                        sda_oe <= ~tx[6];
                        tx     <= {tx[5:0], 1'b0};
                     end
                  end
               end
               ST_RDATA_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_q;
                     ptr  <= ptr + PTR_ONE;
                  end
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (mack) begin
                        tx     <= rd_data[6:0];
                        sda_oe <= ~rd_data[7];
                        state  <= ST_RDATA;
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_rf_pagecommit.sv
module i2c_rf_pagecommit #(
   parameter int ADDR_W     = 8,
   parameter int PAGE_BYTES = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ptr_load,
   input  logic [ADDR_W-1:0]     ptr,
   input  logic                  we,
   input  logic [$clog2(PAGE_BYTES)-1:0] woff,
   input  logic                  stop_det,
   output logic                  commit,
   output logic [ADDR_W-1:0]     commit_base,
   output logic [PAGE_BYTES-1:0] commit_mask
);

   localparam int PAGE_W = $clog2(PAGE_BYTES);
   localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(PAGE_BYTES - 1);

   logic [PAGE_BYTES-1:0] pend;
   logic [ADDR_W-1:0]     base;
   logic                  take;

   assign take = stop_det && (pend != '0);

   generate
      for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
         logic slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= 1'b0;
            end else if (ptr_load || take) begin
               slot_q <= 1'b0;
            end else if (we && woff == PAGE_W'(i)) begin
               slot_q <= 1'b1;
            end
         end
         assign pend[i] = slot_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base        <= '0;
         commit      <= 1'b0;
         commit_base <= '0;
         commit_mask <= '0;
      end else begin
         commit <= take;
         if (ptr_load) begin
            base <= ptr & ~OFF_MASK;
         end
         if (take) begin
            commit_base <= base;
            commit_mask <= pend;
         end
      end
   end

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
   parameter int ADDR_W      = 8,
   parameter int PAGE_BYTES  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   input  logic [1:0]            strap_i,
   output logic [ADDR_W-1:0]     reg_raddr_o,
   input  logic [7:0]            reg_rdata_i,
   output logic                  reg_we_o,
   output logic [ADDR_W-1:0]     reg_waddr_o,
   output logic [7:0]            reg_wdata_o,
   output logic                  commit_o,
   output logic [ADDR_W-1:0]     commit_base_o,
   output logic [PAGE_BYTES-1:0] commit_mask_o
);

   localparam int PAGE_W = $clog2(PAGE_BYTES);

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_aw
         $error("ADDR_W must lie in 1..8");
      end
      if (PAGE_BYTES < 2 || (1 << PAGE_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if (PAGE_W > ADDR_W) begin : g_bad_fit
         $error("page larger than address space");
      end
   endgenerate

   logic              sda_q;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic [ADDR_W-1:0] ptr;
   logic              ptr_load;

   i2c_rf_linefront #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .sda_q    (sda_q),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   i2c_rf_engine #(
      .ADDR_W    (ADDR_W),
      .PAGE_BYTES(PAGE_BYTES)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .sda_q    (sda_q),
      .strap_i  (strap_i),
      .rd_data  (reg_rdata_i),
      .sda_oe   (sda_oe_o),
      .ptr      (ptr),
      .ptr_load (ptr_load),
      .we       (reg_we_o),
      .waddr    (reg_waddr_o),
      .wdata    (reg_wdata_o)
   );

   i2c_rf_pagecommit #(
      .ADDR_W    (ADDR_W),
      .PAGE_BYTES(PAGE_BYTES)
   ) u_commit (
      .clk        (clk),
      .rst_n      (rst_n),
      .ptr_load   (ptr_load),
      .ptr        (ptr),
      .we         (reg_we_o),
      .woff       (reg_waddr_o[PAGE_W-1:0]),
      .stop_det   (stop_det),
      .commit     (commit_o),
      .commit_base(commit_base_o),
      .commit_mask(commit_mask_o)
   );

   assign reg_raddr_o = ptr;

endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk #(
   parameter int PAGE_BYTES = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sda_oe_o,
   input logic                  reg_we_o,
   input logic                  commit_o,
   input logic [PAGE_BYTES-1:0] commit_mask_o,
   input logic                  start_det,
   input logic                  stop_det
);

   a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o);

   a_r6_commit_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> commit_mask_o != '0);

   a_r6_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> $past(stop_det));

   a_r4_write_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we_o |-> $past(sda_oe_o));

   a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);

   a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe_o);

   a_r4_no_write_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !reg_we_o);

endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(
   .PAGE_BYTES(PAGE_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sda_oe_o     (sda_oe_o),
   .reg_we_o     (reg_we_o),
   .commit_o     (commit_o),
   .commit_mask_o(commit_mask_o),
   .start_det    (start_det),
   .stop_det     (stop_det)
);

// File: tb/i2c_regfile_target_test.sv
`timescale 1ns/1ps
module i2c_regfile_target_test;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] strap = 2'b00;
   logic       sda_oe;
   logic [7:0] raddr, waddr, wdata, cbase, cmask;
   logic       we, commit;
   logic [7:0] regs [0:255];
   logic       sda_line;

   int checks = 0;
   int fails = 0;
   int commit_cnt = 0;
   int oe_cnt = 0;
   logic [7:0] last_base = '0;
   logic [7:0] last_mask = '0;
   bit done = 0;

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_regfile_target uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_line),
      .sda_oe_o     (sda_oe),
      .strap_i      (strap),
      .reg_raddr_o  (raddr),
      .reg_rdata_i  (regs[raddr]),
      .reg_we_o     (we),
      .reg_waddr_o  (waddr),
      .reg_wdata_o  (wdata),
      .commit_o     (commit),
      .commit_base_o(cbase),
      .commit_mask_o(cmask)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) regs[i] <= 8'(i) ^ 8'h5A;
      end else begin
         if (we) regs[waddr] <= wdata;
         if (commit) begin
            commit_cnt <= commit_cnt + 1;
            last_base  <= cbase;
            last_mask  <= cmask;
         end
         if (sda_oe) oe_cnt <= oe_cnt + 1;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl_m = 1'b0;
      end
      wq(); sda_m = give_ack ? 1'b0 : 1'b1;
      wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
   endtask

   task automatic t_reset();
      chk("R9", "sda_oe after reset", sda_oe, 0);
      chk("R9", "reg_we after reset", we, 0);
      chk("R9", "commit after reset", commit, 0);
   endtask

   task automatic t_single_write();
      logic a;
      int c0 = commit_cnt;
      bus_start();
      wr_byte(8'hB0, a); chk("R2", "ack on B0", a, 1);
      wr_byte(8'h12, a); chk("R4", "ack on pointer", a, 1);
      wr_byte(8'hA5, a); chk("R4", "ack on data", a, 1);
      chk("R4", "live reg updated before STOP", regs[8'h12], 8'hA5);
      chk("R6", "no commit before STOP", commit_cnt - c0, 0);
      bus_stop();
      chk("R6", "one commit after STOP", commit_cnt - c0, 1);
      chk("R6", "commit base", last_base, 8'h10);
      chk("R6", "commit mask", last_mask, 8'h04);
   endtask

   task automatic t_foreign();
      logic a;
      int c0 = commit_cnt;
      int o0;
      bus_start();
      wr_byte(8'hB2, a); chk("R3", "nack on foreign address", a, 0);
      o0 = oe_cnt;
      wr_byte(8'h12, a);
      wr_byte(8'h77, a);
      chk("R3", "no drive while unaddressed", oe_cnt - o0, 0);
      bus_stop();
      chk("R3", "register untouched", regs[8'h12], 8'hA5);
      chk("R3", "no commit", commit_cnt - c0, 0);
   endtask

   task automatic t_strap();
      logic a;
      strap = 2'b11;
      repeat (4) @(negedge clk);
      bus_start();
      wr_byte(8'hB0, a); chk("R10", "B0 refused with straps 11", a, 0);
      bus_stop();
      bus_start();
      wr_byte(8'hBC, a); chk("R10", "BC accepted with straps 11", a, 1);
      wr_byte(8'h40, a);
      wr_byte(8'h3C, a);
      bus_stop();
      chk("R10", "write via strapped address", regs[8'h40], 8'h3C);
      chk("R6", "commit base strapped", last_base, 8'h40);
      chk("R6", "commit mask strapped", last_mask, 8'h01);
      strap = 2'b00;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_page_wrap();
      logic a;
      logic [7:0] adr [0:5] = '{8'h25, 8'h26, 8'h27, 8'h20, 8'h21, 8'h22};
      int c0 = commit_cnt;
      bus_start();
      wr_byte(8'hB0, a);
      wr_byte(8'h25, a);
      for (int k = 0; k < 6; k++) wr_byte(8'hD0 + 8'(k), a);
      bus_stop();
      for (int k = 0; k < 6; k++) chk("R5", "wrapped write data", regs[adr[k]], 8'hD0 + 8'(k));
      chk("R5", "next page untouched", regs[8'h28], 8'h28 ^ 8'h5A);
      chk("R6", "single commit", commit_cnt - c0, 1);
      chk("R6", "wrap commit base", last_base, 8'h20);
      chk("R6", "wrap commit mask", last_mask, 8'hE7);
   endtask

   task automatic t_overlap();
      logic a;
      int c0 = commit_cnt;
      bus_start();
      wr_byte(8'hB0, a);
      wr_byte(8'h33, a);
      for (int k = 0; k < 9; k++) wr_byte(8'hE0 + 8'(k), a);
      bus_stop();
      chk("R5", "ninth byte overwrites first", regs[8'h33], 8'hE8);
      chk("R5", "offset 7", regs[8'h37], 8'hE4);
      chk("R5", "offset 0 after wrap", regs[8'h30], 8'hE5);
      chk("R5", "offset 2 after wrap", regs[8'h32], 8'hE7);
      chk("R5", "next page untouched", regs[8'h38], 8'h38 ^ 8'h5A);
      chk("R6", "one commit for overlap", commit_cnt - c0, 1);
      chk("R6", "full mask", last_mask, 8'hFF);
      chk("R6", "overlap base", last_base, 8'h30);
   endtask

   task automatic t_seq_read();
      logic a;
      logic [7:0] b;
      int c0 = commit_cnt;
      int o0;
      bus_start();
      wr_byte(8'hB0, a);
      wr_byte(8'h25, a);
      bus_start();
      wr_byte(8'hB1, a); chk("R2", "ack on B1", a, 1);
      rd_byte(1'b1, b); chk("R7", "read first byte", b, 8'hD0);
      rd_byte(1'b1, b); chk("R7", "read second byte", b, 8'hD1);
      rd_byte(1'b0, b); chk("R7", "read third byte", b, 8'hD2);
      chk("R8", "SDA released after NACK", sda_oe, 0);
      o0 = oe_cnt;
      rd_byte(1'b0, b);
      chk("R8", "no drive after NACK", oe_cnt - o0, 0);
      chk("R8", "bus reads idle after NACK", b, 8'hFF);
      bus_stop();
      chk("R6", "no commit without data bytes", commit_cnt - c0, 0);
   endtask

   task automatic t_cross_read();
      logic a;
      logic [7:0] b;
      bus_start();
      wr_byte(8'hB0, a);
      wr_byte(8'h27, a);
      bus_start();
      wr_byte(8'hB1, a);
      rd_byte(1'b1, b); chk("R7", "read at page end", b, 8'hD2);
      rd_byte(1'b0, b); chk("R7", "read crosses page", b, 8'h28 ^ 8'h5A);
      bus_stop();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_single_write();
      t_foreign();
      t_strap();
      t_page_wrap();
      t_overlap();
      t_seq_read();
      t_cross_read();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule